// File: doc/BRIEF.md
# Serial-Clock Hold Synchronisation and Power-Down Controller

This block sits beside the conversion timing logic of a delta-sigma converter's digital back end. It watches the externally driven serial clock, which normally idles low, and a one-clock tick that the timing logic raises once per conversion cycle. The block counts how many ticks in a row arrive while the serial clock is held high. The count clears whenever the synchronised serial clock is low, and it stops at the power-down threshold.

When the hold reaches the synchronisation threshold, the block requests a modulator reset. It also takes over the shared ready/data output. That output is driven low for a short pulse and then held high. When the hold reaches the power-down threshold, the block also raises a power-down request.

A falling edge of the serial clock releases both requests. The release produces a one-clock restart pulse, which clears the decimator and the conversion timer. A further one-clock pulse marks the first conversion tick after release, which is the first result that carries valid data. The analog modulator, the filter arithmetic and the serial shifter are outside this block. The two requests are outputs that drive those blocks.

Top module: `clkhold_ctrl`

## Requirements
- R1: While rst_n is low and on the first cycles after it rises, mod_reset, pwr_down, restart and first_valid are 0, and ready_out equals ready_n_in.
- R2: While mod_reset is 0, ready_out equals ready_n_in in every cycle.
- R3: If the serial clock is held high for fewer than SYNC_CYCLES (default 4) conversion ticks and then goes low, mod_reset never asserts and restart never pulses.
- R4: On the fourth consecutive tick with the synchronised serial clock high, mod_reset is still 0 in the cycle of that tick and becomes 1 one clock later. From that clock, ready_out is 0 for exactly LOW_PULSE (default 3) clocks. It is then 1 for as long as mod_reset stays 1, whatever ready_n_in is.
- R5: pwr_down asserts one clock after the twentieth consecutive high tick (PD_CYCLES) and not after the nineteenth. Whenever pwr_down is 1, mod_reset is also 1.
- R6: A falling edge on sclk_in reaches the core through a two-flop synchroniser. On the third rising clock edge after the fall, mod_reset and pwr_down clear together and restart is 1 for exactly one clock. restart pulses only when a reset was active.
- R7: After a restart, first_valid is 1 for exactly one clock, in the clock that follows the first conversion tick. Later ticks produce no first_valid.
- R8: The consecutive-tick count clears whenever the synchronised serial clock is low. Three high ticks, a short low, and then three more high ticks do not assert mod_reset.
- R9: The count saturates at PD_CYCLES. With further ticks held high, pwr_down stays 1, and a later fall still releases it as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_in | input | 1 | Serial clock pin, asynchronous to clk |
| cycle_tick | input | 1 | One-clock pulse per conversion cycle |
| ready_n_in | input | 1 | Ready/data level from the serial shifter |
| ready_out | output | 1 | Ready/data pin level after override |
| mod_reset | output | 1 | Modulator reset request |
| pwr_down | output | 1 | Power-down request |
| restart | output | 1 | One-clock clear for decimator and timer |
| first_valid | output | 1 | Marks the first valid result after release |

## Verification
The bench measures the override pulse clock by clock. A design that entered reset one tick early or late, or that produced a pulse of the wrong width, changes the count of low samples. The tests probe both sides of the thresholds: nineteen against twenty ticks, and three against four. A counter that fails to clear on a brief low is exposed when two short holds are split by a gap and would add up to a false reset. Release is timed to the exact edge after the synchroniser, and later ticks are checked for a second first_valid. A design that skips the synchroniser, misses the saturation, or repeats the marker would fail those checks.

// File: rtl/clkhold_pkg.sv
// Shared types for the serial-clock hold controller.
// Assumes: nothing beyond IEEE 1800-2017.
package clkhold_pkg;

    // Source selection for the ready/data pin.
    typedef enum logic [1:0] {
        OUT_PASS = 2'd0,   // follow the serial shifter
        OUT_LOW  = 2'd1,   // override pulse after reset entry
        OUT_HIGH = 2'd2    // held high while in reset
    } out_mode_e;

endpackage

// File: rtl/clkhold_sync.sv
// Brings the serial clock pin into the system clock domain and flags its
// falling edge. Assumes the pin is asynchronous and free of glitches
// shorter than a clock period.
module clkhold_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              level_d;

    // Synchroniser chain: stage 0 samples the pin.
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    // Delayed copy of the synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign fall  = level_d & ~chain[STAGES-1];
endmodule

// File: rtl/clkhold_count.sv
// Counts consecutive conversion ticks seen with the synchronised serial
// clock high. Clears whenever the level is low and saturates at LIMIT.
// Assumes tick is a single-clock pulse.
module clkhold_count #(
    parameter int LIMIT = 20,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         level,
    input  logic         tick,
    output logic [W-1:0] count
);
    // Consecutive-tick counter with clear on low and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)                                count <= '0;
        else if (!level)                           count <= '0;
        else if (tick && (count != W'(LIMIT)))     count <= count + 1'b1;
    end
endmodule

// File: rtl/clkhold_seq.sv
// Holds the reset and power-down requests, times the override pulse on
// the ready pin, and issues the restart and first-valid pulses.
// Assumes count comes from clkhold_count and fall from clkhold_sync.
module clkhold_seq
    import clkhold_pkg::*;
#(
    parameter int SYNC_AT   = 4,
    parameter int PD_AT     = 20,
    parameter int LOW_PULSE = 3,
    localparam int CW = $clog2(PD_AT + 1),
    localparam int PW = $clog2(LOW_PULSE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          fall,
    input  logic          tick,
    output logic          rst_req,
    output logic          pd_req,
    output logic          restart,
    output logic          first_valid,
    output out_mode_e     mode
);
    logic          enter_rst;
    logic [PW-1:0] pulse_left;
    logic          await_first;

    assign enter_rst = (count >= CW'(SYNC_AT)) && !rst_req && !fall;

    // Reset and power-down request flags, released by a falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || fall) begin
            rst_req <= 1'b0;
            pd_req  <= 1'b0;
        end else begin
            if (count >= CW'(SYNC_AT)) rst_req <= 1'b1;
            if (count >= CW'(PD_AT))   pd_req  <= 1'b1;
        end
    end

    // Override pulse length counter, loaded on reset entry.
    always_ff @(posedge clk) begin
        if (!rst_n || fall)       pulse_left <= '0;
        else if (enter_rst)       pulse_left <= PW'(LOW_PULSE);
        else if (pulse_left != 0) pulse_left <= pulse_left - 1'b1;
    end

    // One-clock restart on release of an active reset.
    always_ff @(posedge clk) begin
        if (!rst_n) restart <= 1'b0;
        else        restart <= fall && rst_req;
    end

    // Wait for the first tick after release and mark it once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            await_first <= 1'b0;
            first_valid <= 1'b0;
        end else begin
            first_valid <= await_first && tick;
            if (fall && rst_req)  await_first <= 1'b1;
            else if (tick)        await_first <= 1'b0;
        end
    end

    // Pin source selection.
    always_comb begin
        if (pulse_left != 0) mode = OUT_LOW;
        else if (rst_req)    mode = OUT_HIGH;
        else                 mode = OUT_PASS;
    end
endmodule

// File: rtl/clkhold_ctrl.sv
// Top of the serial-clock hold controller: synchroniser, hold counter and
// request sequencer, with the ready/data pin multiplexer.
// Assumes cycle_tick comes from the conversion timer in the clk domain.
module clkhold_ctrl
    import clkhold_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SYNC_CYCLES = 4,
    parameter int PD_CYCLES   = 20,
    parameter int LOW_PULSE   = 3,
    localparam int CW = $clog2(PD_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic cycle_tick,
    input  logic ready_n_in,
    output logic ready_out,
    output logic mod_reset,
    output logic pwr_down,
    output logic restart,
    output logic first_valid
);
    logic          sclk_lvl;
    logic          sclk_fall;
    logic [CW-1:0] hold_cnt;
    out_mode_e     pin_mode;

    clkhold_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (sclk_in),
        .level (sclk_lvl),
        .fall  (sclk_fall)
    );

    clkhold_count #(.LIMIT(PD_CYCLES)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sclk_lvl),
        .tick  (cycle_tick),
        .count (hold_cnt)
    );

    clkhold_seq #(
        .SYNC_AT   (SYNC_CYCLES),
        .PD_AT     (PD_CYCLES),
        .LOW_PULSE (LOW_PULSE)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .count       (hold_cnt),
        .fall        (sclk_fall),
        .tick        (cycle_tick),
        .rst_req     (mod_reset),
        .pd_req      (pwr_down),
        .restart     (restart),
        .first_valid (first_valid),
        .mode        (pin_mode)
    );

    // Ready/data pin multiplexer.
    always_comb begin
        case (pin_mode)
            OUT_LOW:  ready_out = 1'b0;
            OUT_HIGH: ready_out = 1'b1;
            default:  ready_out = ready_n_in;
        endcase
    end
endmodule

// File: rtl/clkhold_chk.sv
// Property checker for clkhold_ctrl, attached by bind.
module clkhold_chk (
    input logic clk,
    input logic rst_n,
    input logic ready_n_in,
    input logic ready_out,
    input logic mod_reset,
    input logic pwr_down,
    input logic restart,
    input logic first_valid
);
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_reset |-> ready_out == ready_n_in); // R2
    AST_ENTRY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_reset) |-> !ready_out); // R4
    AST_PD_NEEDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> mod_reset); // R5
    AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart); // R6
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> (!mod_reset && !pwr_down)); // R6
    AST_FELL_HAS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_reset) |-> restart); // R6
    AST_FIRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        first_valid |=> !first_valid); // R7
    AST_PD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_down) |-> restart); // R9
endmodule

bind clkhold_ctrl clkhold_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready_n_in  (ready_n_in),
    .ready_out   (ready_out),
    .mod_reset   (mod_reset),
    .pwr_down    (pwr_down),
    .restart     (restart),
    .first_valid (first_valid)
);

// File: tb/clkhold_ctrl_test.sv
module clkhold_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_in = 1'b0;
    logic cycle_tick = 1'b0;
    logic ready_n_in = 1'b1;
    logic ready_out, mod_reset, pwr_down, restart, first_valid;
    int   checks = 0;
    int   errors = 0;
    logic last_fv;
    logic saw_rst;
    logic saw_rs;

    always #5 clk = ~clk;

    clkhold_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .cycle_tick(cycle_tick),
        .ready_n_in(ready_n_in), .ready_out(ready_out), .mod_reset(mod_reset),
        .pwr_down(pwr_down), .restart(restart), .first_valid(first_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One conversion tick; samples first_valid in the clock that follows.
    task automatic tick();
        @(negedge clk) cycle_tick = 1'b1;
        @(negedge clk) cycle_tick = 1'b0;
        last_fv = first_valid;
        if (mod_reset) saw_rst = 1'b1;
        if (restart)   saw_rs  = 1'b1;
        repeat (4) begin
            @(negedge clk);
            if (mod_reset) saw_rst = 1'b1;
            if (restart)   saw_rs  = 1'b1;
        end
    endtask

    task automatic go_high();
        @(negedge clk) sclk_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Drops sclk and checks the release timing; expects a reset active.
    task automatic release_check(input string req);
        @(negedge clk) sclk_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk({req, " reset held before third edge"}, mod_reset, 1);
        chk({req, " no restart yet"}, restart, 0);
        @(negedge clk);
        chk({req, " restart pulse"}, restart, 1);
        chk({req, " mod_reset cleared"}, mod_reset, 0);
        chk({req, " pwr_down cleared"}, pwr_down, 0);
        @(negedge clk);
        chk({req, " restart one clock"}, restart, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 mod_reset in reset", mod_reset, 0);
        chk("R1 pwr_down in reset", pwr_down, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1 restart after reset", restart, 0);
        chk("R1 first_valid after reset", first_valid, 0);
        chk("R1 ready follows input", ready_out, 1);
    endtask

    task automatic t_pass();
        ready_n_in = 1'b0;
        @(negedge clk);
        chk("R2 pass low", ready_out, 0);
        ready_n_in = 1'b1;
        @(negedge clk);
        chk("R2 pass high", ready_out, 1);
    endtask

    task automatic t_short();
        saw_rst = 1'b0; saw_rs = 1'b0;
        go_high();
        repeat (3) tick();
        @(negedge clk) sclk_in = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (restart) saw_rs = 1'b1;
        end
        chk("R3 no reset on short hold", saw_rst, 0);
        chk("R3 no restart on short hold", saw_rs, 0);
    endtask

    task automatic t_clear();
        saw_rst = 1'b0;
        go_high();
        repeat (3) tick();
        @(negedge clk) sclk_in = 1'b0;
        repeat (4) @(negedge clk);
        go_high();
        repeat (3) tick();
        chk("R8 counter cleared by low", saw_rst, 0);
        @(negedge clk) sclk_in = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_sync();
        int lows;
        ready_n_in = 1'b0;
        go_high();
        repeat (3) tick();
        chk("R4 no reset after third tick", mod_reset, 0);
        @(negedge clk) cycle_tick = 1'b1;
        @(negedge clk) cycle_tick = 1'b0;
        chk("R4 reset not in tick cycle", mod_reset, 0);
        @(negedge clk);
        chk("R4 reset one clock later", mod_reset, 1);
        lows = 0;
        while (ready_out == 1'b0 && lows < 10) begin
            lows++;
            @(negedge clk);
        end
        chk("R4 low pulse width", lows, 3);
        repeat (5) @(negedge clk);
        chk("R4 ready held high", ready_out, 1);
        chk("R5 no power-down at sync", pwr_down, 0);
        release_check("R6");
        chk("R2 pass after release", ready_out, 0);
        ready_n_in = 1'b1;
        tick();
        chk("R7 first_valid on first tick", last_fv, 1);
        tick();
        chk("R7 no second first_valid", last_fv, 0);
    endtask

    task automatic t_pd();
        go_high();
        repeat (19) tick();
        chk("R5 reset after 19", mod_reset, 1);
        chk("R5 no power-down after 19", pwr_down, 0);
        @(negedge clk) cycle_tick = 1'b1;
        @(negedge clk) cycle_tick = 1'b0;
        chk("R5 power-down not in tick cycle", pwr_down, 0);
        @(negedge clk);
        chk("R5 power-down after 20", pwr_down, 1);
        repeat (5) tick();
        chk("R9 power-down held when saturated", pwr_down, 1);
        chk("R9 ready held high", ready_out, 1);
        release_check("R9");
        tick();
        chk("R7 first_valid after power-down", last_fv, 1);
    endtask

    initial begin
        last_fv = 1'b0; saw_rst = 1'b0; saw_rs = 1'b0;
        t_reset();
        t_pass();
        t_short();
        t_clear();
        t_sync();
        t_pd();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule